// File: doc/BRIEF.md
# Saturating Signed Up/Down Counter

This block keeps an 8-bit two's-complement count that moves by one step on each rising clock edge while its enable is high. The direction of the step comes from two single-bit compare inputs: when the two bits agree the count rises, and when they disagree it falls. The count never wraps. It sticks at +127 when asked to rise and at -128 when asked to fall, so it behaves like a bounded signed accumulator of agreement between two bit streams.

An active-high reset clears the count to zero as soon as it is asserted, without waiting for a clock edge, and it outranks every other input. A low enable freezes the count. All pins are plain control and status wires. The block carries no data stream, so it has no valid/ready handshake and never applies back-pressure.

Top module: `sat_updown_ctr`

## Requirements
- R1: Asserting `rst_i` forces `count_o` to 0x00 at once, without waiting for a clock edge.
- R2: On a rising edge with `en_i` high, `bit_a_i == bit_b_i`, and a count that is not 0x7F, the count increases by one.
- R3: On a rising edge with `en_i` high, `bit_a_i != bit_b_i`, and a count that is not 0x80, the count decreases by one.
- R4: With the count at 0x7F (+127), an edge that asks to increase leaves the count at 0x7F.
- R5: With the count at 0x80 (-128), an edge that asks to decrease leaves the count at 0x80.
- R6: On a rising edge with `en_i` low, the count holds whatever the compare bits are.
- R7: While `rst_i` is high, the count stays 0x00 across clock edges, even with `en_i` high and any compare bits.
- R8: The limits use the signed view of the count. 0xFF (-1) increases to 0x00 and 0x00 decreases to 0xFF. After sitting at a limit, a step in the other direction moves the count off it (0x7F to 0x7E, 0x80 to 0x81).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Asynchronous reset, active high, clears the count |
| en_i | input | 1 | Synchronous count enable |
| bit_a_i | input | 1 | First compare bit |
| bit_b_i | input | 1 | Second compare bit |
| count_o | output | WIDTH (8) | Current count, two's complement |

## Verification
The bound checker watches every clock edge. It checks the single step up or down, the clamp at each limit, the hold while the enable is low, and the zero count while reset is high. Some behaviours only the bench's scenarios can show. One is that reset takes effect between clock edges. Others are the long climb to +127 and the long descent to -128. The last is the crossing of zero through 0xFF, which separates a signed clamp from an unsigned one.

// File: rtl/sat_updown_ctr_pkg.sv
package sat_updown_ctr_pkg;

  // Direction of a single counting step.
  typedef enum logic {
    STEP_DOWN = 1'b0,
    STEP_UP   = 1'b1
  } step_dir_e;

endpackage

// File: rtl/sat_updown_ctr_dir.sv
// Picks the step direction: agreement of the two bits means up.
module sat_updown_ctr_dir
  import sat_updown_ctr_pkg::*;
(
  input  logic      bit_a_i,
  input  logic      bit_b_i,
  output step_dir_e dir_o
);

  always_comb begin
    if (bit_a_i ~^ bit_b_i) dir_o = STEP_UP;
    else                    dir_o = STEP_DOWN;
  end

endmodule

// File: rtl/sat_updown_ctr_step.sv
// Computes the next count, clamping at the signed extremes.
module sat_updown_ctr_step
  import sat_updown_ctr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur_i,
  input  step_dir_e        dir_i,
  output logic [WIDTH-1:0] nxt_o
);

  localparam logic [WIDTH-1:0] CEIL  = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] FLOOR = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ONE   = WIDTH'(1);

  logic at_ceil;
  logic at_floor;

  assign at_ceil  = (cur_i == CEIL);
  assign at_floor = (cur_i == FLOOR);

  always_comb begin
    nxt_o = cur_i;
    unique case (dir_i)
      STEP_UP:   if (!at_ceil)  nxt_o = cur_i + ONE;
      STEP_DOWN: if (!at_floor) nxt_o = cur_i - ONE;
      default:   nxt_o = cur_i;
    endcase
  end

endmodule

// File: rtl/sat_updown_ctr.sv
module sat_updown_ctr
  import sat_updown_ctr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             bit_a_i,
  input  logic             bit_b_i,
  output logic [WIDTH-1:0] count_o
);

  step_dir_e        dir;
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_nxt;

  sat_updown_ctr_dir u_dir (
    .bit_a_i (bit_a_i),
    .bit_b_i (bit_b_i),
    .dir_o   (dir)
  );

  sat_updown_ctr_step #(.WIDTH(WIDTH)) u_step (
    .cur_i (count_q),
    .dir_i (dir),
    .nxt_o (count_nxt)
  );

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)     count_q <= '0;
    else if (en_i) count_q <= count_nxt;
  end

  assign count_o = count_q;

endmodule

// File: rtl/sat_updown_ctr_chk.sv
module sat_updown_ctr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             en_i,
  input logic             bit_a_i,
  input logic             bit_b_i,
  input logic [WIDTH-1:0] count_o
);

  localparam logic [WIDTH-1:0] CEIL  = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] FLOOR = {1'b1, {(WIDTH-1){1'b0}}};

  a_r2_step_up: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && bit_a_i == bit_b_i && count_o != CEIL)
      |=> count_o == WIDTH'($past(count_o) + WIDTH'(1)));

  a_r3_step_down: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && bit_a_i != bit_b_i && count_o != FLOOR)
      |=> count_o == WIDTH'($past(count_o) - WIDTH'(1)));

  a_r4_clamp_ceil: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && bit_a_i == bit_b_i && count_o == CEIL) |=> count_o == CEIL);

  a_r5_clamp_floor: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && bit_a_i != bit_b_i && count_o == FLOOR) |=> count_o == FLOOR);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(count_o));

  // R7: reset held across an edge keeps the count at zero
  a_r7_reset_zero: assert property (@(posedge clk_i)
    rst_i |-> count_o == '0);

endmodule

bind sat_updown_ctr sat_updown_ctr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .en_i    (en_i),
  .bit_a_i (bit_a_i),
  .bit_b_i (bit_b_i),
  .count_o (count_o)
);

// File: tb/sat_updown_ctr_tb.sv
module sat_updown_ctr_tb;

  localparam int W = 8;
  localparam int NV = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         a = 1'b0;
  logic         b = 1'b0;
  logic [W-1:0] cnt;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sat_updown_ctr #(.WIDTH(W)) u_dut (
    .clk_i (clk), .rst_i (rst), .en_i (en),
    .bit_a_i (a), .bit_b_i (b), .count_o (cnt)
  );

  // {en, a, b, expected count after the edge}; starts from 0x00
  localparam logic [10:0] VEC [NV] = '{
    {3'b100, 8'h01},  // R2 equal 00 -> up
    {3'b111, 8'h02},  // R2 equal 11 -> up
    {3'b101, 8'h01},  // R3 differ -> down
    {3'b110, 8'h00},  // R3 differ -> down
    {3'b110, 8'hFF},  // R8 0x00 down -> 0xFF
    {3'b000, 8'hFF},  // R6 hold with equal bits
    {3'b010, 8'hFF},  // R6 hold with differing bits
    {3'b111, 8'h00},  // R8 0xFF up -> 0x00
    {3'b100, 8'h01},  // R2
    {3'b101, 8'h00}   // R3
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: count=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge (one edge later)
  task automatic step(input logic e, input logic xa, input logic xb);
    en = e; a = xa; b = xb;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: count=%h expected=done", cnt);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 reset state", cnt, 8'h00);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][10], VEC[i][9], VEC[i][8]);
      check("R2/R3/R6/R8 vector", cnt, VEC[i][7:0]);
    end
    // climb to the ceiling (count is 0x00 here)
    for (int i = 0; i < 127; i++) step(1'b1, 1'b1, 1'b1);
    check("R2 climb to 0x7F", cnt, 8'h7F);
    step(1'b1, 1'b0, 1'b0);
    check("R4 clamp at 0x7F", cnt, 8'h7F);
    step(1'b1, 1'b1, 1'b1);
    check("R4 clamp at 0x7F again", cnt, 8'h7F);
    step(1'b1, 1'b0, 1'b1);
    check("R8 leave ceiling", cnt, 8'h7E);
    // asynchronous reset between edges
    #2 rst = 1'b1;
    #1 check("R1 async clear", cnt, 8'h00);
    @(negedge clk);
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    check("R7 reset outranks enable", cnt, 8'h00);
    rst = 1'b0;
    // descend to the floor
    for (int i = 0; i < 128; i++) step(1'b1, 1'b1, 1'b0);
    check("R3 descend to 0x80", cnt, 8'h80);
    step(1'b1, 1'b0, 1'b1);
    check("R5 clamp at 0x80", cnt, 8'h80);
    step(1'b0, 1'b1, 1'b1);
    check("R6 hold at floor", cnt, 8'h80);
    step(1'b1, 1'b1, 1'b1);
    check("R8 leave floor", cnt, 8'h81);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule